// File: doc/BRIEF.md
# Late-Sampling Checked Pipeline Register

This block is a bank of pipeline flops that checks its own capture. Each bit has a main flop on the system clock and a second copy that samples the same data input on a separately supplied late clock, about half a period behind. If the stage logic feeding the register finishes after the main edge but before the late edge, the two copies disagree. That disagreement is turned into an error flag and marks the data leaving the register as unusable for that cycle.

The registered output stage presents the main copy one edge after capture, together with a valid flag and the error flag for that same word. When the surrounding pipeline control raises the recover strobe, the main copy is reloaded from the late copy instead of from the data input. The corrected word then appears at the output one cycle later. A separate metastability indication, which may arrive asynchronously, is resynchronised and raised as a panic output that asks for a full pipeline flush. While panic is high, the output is never marked valid.

Top module: `lateshadow_reg`

## Requirements
- R1: An active-low reset clears both copies of every bit and drives q to 0 and q_valid, err and panic to 0.
- R2: Without recover, the main copy takes d at each rising edge of clk, and that word appears on q after the next rising edge of clk.
- R3: The late copy takes d at each rising edge of clk_late. A change of d after the main edge and before the late edge reaches only the late copy.
- R4: After a clk edge, err is 1 exactly when at least one bit of the main copy held before that edge differed from the late copy held before that edge.
- R5: The word presented on q after an edge has q_valid 0 whenever err is 1 in that same cycle.
- R6: When recover is 1 at a clk edge, the main copy loads the late copy and ignores d. The loaded word appears on q after the following edge.
- R7: A 1 on meta_flag sampled at a clk edge appears on panic after SYNC_STAGES clk edges, counting that edge. panic follows meta_flag through the same delay.
- R8: q_valid is 0 in every cycle in which panic is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock, rising edge |
| clk_late | input | 1 | Delayed clock for the late copy, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| d | input | WIDTH | Data from the stage logic |
| recover | input | 1 | Reload main copy from late copy at this edge |
| meta_flag | input | 1 | Metastability indication, may be asynchronous |
| q | output | WIDTH | Registered output word |
| q_valid | output | 1 | Output word is trustworthy |
| err | output | 1 | Main and late copies disagreed for the output word |
| panic | output | 1 | Synchronised flush request |

## Verification
The hardest condition to produce is a late-arriving input: the bench must change d inside the half-period between a clk edge and the following clk_late edge. Otherwise the two copies never differ and recovery has nothing to correct. The bench drives regular data well after the late edge, and on randomly chosen cycles it flips one bit of d one nanosecond after the main edge. That gives a mismatch of known content. Random recover pulses are mixed in, some of them while d carries a different word, so that the reload from the late copy is visible against the data input.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
   localparam int unsigned LSR_MAX_WIDTH = 1024;
   localparam int unsigned LSR_MAX_SYNC  = 4;

   function automatic logic any_set(input logic [LSR_MAX_WIDTH-1:0] v);
      return |v;
   endfunction
endpackage

// File: rtl/lsr_bit_bank.sv
module lsr_bit_bank #(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             clk_late,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   input  logic             recover,
   output logic [WIDTH-1:0] main_q,
   output logic [WIDTH-1:0] late_q,
   output logic [WIDTH-1:0] diff
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic m_r;
      logic s_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       m_r <= 1'b0;
         else if (recover) m_r <= s_r;
         else              m_r <= d[i];
      end

      always_ff @(posedge clk_late or negedge rst_n) begin
         if (!rst_n) s_r <= 1'b0;
         else        s_r <= d[i];
      end

      assign main_q[i] = m_r;
      assign late_q[i] = s_r;
      assign diff[i]   = m_r ^ s_r;
   end

   AST_RECOVER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      recover |=> main_q == $past(late_q)); // R6
   AST_MAIN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      !recover |=> main_q == $past(d)); // R2
endmodule

// File: rtl/lsr_meta_sync.sv
module lsr_meta_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   logic [STAGES-1:0] chain;

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[k] <= 1'b0;
            else        chain[k] <= chain[k-1];
         end
      end
   end

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/lateshadow_reg.sv
module lateshadow_reg #(
   parameter int unsigned WIDTH       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             clk_late,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   input  logic             recover,
   input  logic             meta_flag,
   output logic [WIDTH-1:0] q,
   output logic             q_valid,
   output logic             err,
   output logic             panic
);
   import lsr_pkg::*;

   if (WIDTH < 1 || WIDTH > LSR_MAX_WIDTH) begin : g_bad_width
      $error("lateshadow_reg: WIDTH out of range");
   end
   if (SYNC_STAGES < 1 || SYNC_STAGES > LSR_MAX_SYNC) begin : g_bad_sync
      $error("lateshadow_reg: SYNC_STAGES out of range");
   end

   logic [WIDTH-1:0] main_q;
   logic [WIDTH-1:0] late_q;
   logic [WIDTH-1:0] diff;
   logic             mismatch;
   logic             vld_r;
   logic             panic_s;

   lsr_bit_bank #(.WIDTH(WIDTH)) u_bank (
      .clk      (clk),
      .clk_late (clk_late),
      .rst_n    (rst_n),
      .d        (d),
      .recover  (recover),
      .main_q   (main_q),
      .late_q   (late_q),
      .diff     (diff)
   );

   lsr_meta_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (meta_flag),
      .sync_out (panic_s)
   );

   assign mismatch = |diff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q     <= '0;
         vld_r <= 1'b0;
         err   <= 1'b0;
      end else begin
         q     <= main_q;
         vld_r <= ~mismatch;
         err   <= mismatch;
      end
   end

   assign panic   = panic_s;
   assign q_valid = vld_r & ~panic_s;

   AST_ERR_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !q_valid); // R5
   AST_ERR_FROM_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> $past(main_q != late_q)); // R4
   AST_Q_FOLLOWS_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> q == $past(main_q)); // R2
endmodule

// File: tb/sim_lateshadow_reg.sv
module sim_lateshadow_reg;
   localparam int W  = 16;
   localparam int NS = 2;

   logic clk = 1'b0;
   logic clk_late = 1'b0;
   logic rst_n = 1'b0;
   logic [W-1:0] d = '0;
   logic recover = 1'b0;
   logic meta_flag = 1'b0;
   logic [W-1:0] q;
   logic q_valid, err, panic;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   logic [W-1:0] m_mod = '0;
   logic [W-1:0] s_mod = '0;
   logic [NS-1:0] pch = '0;

   lateshadow_reg #(.WIDTH(W), .SYNC_STAGES(NS)) u0 (
      .clk(clk), .clk_late(clk_late), .rst_n(rst_n), .d(d),
      .recover(recover), .meta_flag(meta_flag),
      .q(q), .q_valid(q_valid), .err(err), .panic(panic)
   );

   initial forever #4 clk = ~clk;
   initial begin
      #8;
      forever begin clk_late = 1'b1; #4; clk_late = 1'b0; #4; end
   end

   task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [W-1:0] one_bit(input int k);
      return W'(1) << (k % W);
   endfunction

   task automatic cycle(input logic [W-1:0] a, input logic [W-1:0] b, input bit rec, input bit meta, input string tag);
      logic [W-1:0] eq_q;
      bit eq_v, eq_e;
      d = a; recover = rec; meta_flag = meta;
      @(posedge clk);
      pch   = {pch[NS-2:0], meta};
      eq_e  = (m_mod != s_mod);
      eq_q  = m_mod;
      eq_v  = !eq_e && !pch[NS-1];
      m_mod = rec ? s_mod : a;
      #1 d = b;
      #1;
      chk(q == eq_q, {tag, " R2/R6 q"}, q, eq_q);
      chk(err == eq_e, {tag, " R4 err"}, W'(err), W'(eq_e));
      chk(q_valid == eq_v, {tag, " R5/R8 q_valid"}, W'(q_valid), W'(eq_v));
      chk(panic == pch[NS-1], {tag, " R7 panic"}, W'(panic), W'(pch[NS-1]));
      @(posedge clk_late);
      s_mod = b; // R3: late copy holds the value present at the late edge
      #2;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      #(8 * 100000);
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [W-1:0] a, b;
      void'($urandom(32'h5EED_0017));
      #26;
      // R1: reset state
      chk(q == '0, "R1 q", q, '0);
      chk(q_valid == 1'b0, "R1 q_valid", W'(q_valid), '0);
      chk(err == 1'b0, "R1 err", W'(err), '0);
      chk(panic == 1'b0, "R1 panic", W'(panic), '0);
      rst_n = 1'b1;

      // R2: plain capture of distinct words
      cycle(16'hA5A5, 16'hA5A5, 0, 0, "R2 a");
      cycle(16'h0F0F, 16'h0F0F, 0, 0, "R2 b");
      cycle(16'hFFFF, 16'hFFFF, 0, 0, "R2 c");

      // R3/R4/R5: late arrival on the top bit, then R6 recovery with stalled input
      cycle(16'h1234, 16'h9234, 0, 0, "R3 late");
      cycle(16'h9234, 16'h9234, 1, 0, "R6 rec");
      cycle(16'h9234, 16'h9234, 0, 0, "R6 after");
      cycle(16'h5555, 16'h5555, 0, 0, "R6 clean");

      // R6: recover wins over a different d
      cycle(16'hAAAA, 16'hAAAA, 0, 0, "R6 prep");
      cycle(16'h3333, 16'h3333, 1, 0, "R6 prio");
      cycle(16'h3333, 16'h3333, 0, 0, "R6 prio2");
      cycle(16'h3333, 16'h3333, 0, 0, "R6 prio3");

      // R7/R8: metastability pulse
      cycle(16'h7777, 16'h7777, 0, 1, "R7 meta");
      cycle(16'h7777, 16'h7777, 0, 0, "R7 wait");
      cycle(16'h7777, 16'h7777, 0, 0, "R8 hold");
      cycle(16'h7777, 16'h7777, 0, 0, "R7 clear");

      // random mix
      for (int n = 0; n < 400; n++) begin
         a = W'($urandom);
         b = ($urandom % 4 == 0) ? (a ^ one_bit($urandom)) : a;
         cycle(a, b, ($urandom % 6 == 0), ($urandom % 20 == 0), "RND");
      end

      // R1: reset in mid-run clears again
      #1 rst_n = 1'b0;
      #1;
      chk(q == '0 && err == 1'b0 && panic == 1'b0 && q_valid == 1'b0, "R1 rerun", q, '0);
      finish_run();
   end
endmodule